// File: doc/BRIEF.md
# Symmetric Programmable Systolic FIR

This block is a fully parallel FIR filter for real, signed fixed-point samples. It accepts at most one sample per clock, qualified by a valid strobe. The filter length and the symmetry type (mirrored taps equal, or mirrored taps negated) are fixed when the block is built. The coefficients are not fixed: they arrive on a wide parallel port and may change on any cycle.

Because mirrored taps share one coefficient value, the two delayed samples of each pair are first added, or subtracted for the negated type. A single multiplier then serves the pair. The port therefore carries only the unique half of the impulse response. The products flow down a systolic adder chain with one register per multiplier. The sum is kept at full precision, so the output never wraps.

A synchronous reset abandons all work in flight. The fixed latency is published as a localparam, so a surrounding pipeline can align other signals to the output.

Top module: `symfir_systolic`

## Requirements
- R1: The coefficient port carries NC = ceil(TAPS/2) signed values of CW bits each. Value k sits at bits [k*CW +: CW] and weights the sample k positions behind the newest one, and also its mirror at position TAPS-1-k. For odd TAPS, value NC-1 weights the centre tap alone.
- R2: With ANTI = 0 the expanded response is h[TAPS-1-k] = h[k] = c[k]. The output is sum over i of h[i]*x[n-i].
- R3: With ANTI = 1 the response is h[k] = c[k] and h[TAPS-1-k] = -c[k]. For odd TAPS the centre tap uses the supplied value, which must be zero for a true antisymmetric response.
- R4: data_out is a two's-complement value of OW = DW + CW + ceil(log2(TAPS)) bits. It is exact for all input and coefficient values, including the most negative codes.
- R5: The sample history shifts only on cycles where valid_in is high. data_in on other cycles has no effect on any later output.
- R6: Every sample accepted in cycle t yields exactly one valid_out pulse, in cycle t + LAT, where LAT = NC + 3. valid_out is never high at any other time.
- R7: Each result uses the coefficient vector presented in the same cycle as its newest sample. A coefficient change affects no result whose newest sample was accepted earlier.
- R8: srst high at a clock edge clears the sample history and every pipeline stage. valid_out and data_out are zero in the following cycle, and samples accepted before the reset produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Qualifies data_in and coef_in |
| data_in | input | DW | Signed input sample |
| coef_in | input | NC*CW | Packed unique coefficients |
| valid_out | output | 1 | Marks a result on data_out |
| data_out | output | OW | Signed full-precision result |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Impulse.** An impulse on both the even-length and odd-length builds reads back the expanded response. A swapped coefficient slice, a missing mirror, or a wrong sign in the negated build shows up directly as a wrong tap.
- **Gapped input.** Garbage data is driven between valid strobes. A delay line that shifts every cycle would mix that garbage into the sums.
- **Coefficient changes.** New coefficients are presented with every sample. A design that samples the coefficients late would apply them to results already in flight.
- **Extreme codes.** Most-negative samples meet most-negative coefficients. An accumulator that is too narrow would wrap.
- **Mid-stream reset.** A reset arrives with samples in flight. An incomplete clear would let stale results or stale history leak past it.

// File: rtl/symfir_systolic.sv
module symfir_systolic #(
  parameter int TAPS = 7,
  parameter int DW   = 12,
  parameter int CW   = 12,
  parameter bit ANTI = 1'b0
) (
  input  logic                                   clk,
  input  logic                                   srst,
  input  logic                                   valid_in,
  input  logic signed [DW-1:0]                   data_in,
  input  logic [((TAPS+1)/2)*CW-1:0]             coef_in,
  output logic                                   valid_out,
  output logic signed [DW+CW+$clog2(TAPS)-1:0]   data_out
);
  localparam int NC    = (TAPS + 1) / 2;
  localparam int NPAIR = TAPS / 2;
  localparam int PW    = DW + 1;
  localparam int MW    = PW + CW;
  localparam int OW    = DW + CW + $clog2(TAPS);
  localparam int LAT   = NC + 3;

  logic signed [DW-1:0] dl [TAPS];
  logic [NC*CW-1:0]     coef_q;
  logic [LAT-1:0]       vs;

  always_ff @(posedge clk) begin
    if (srst) begin
      for (int i = 0; i < TAPS; i++) dl[i] <= '0;
    end else if (valid_in) begin
      dl[0] <= data_in;
      for (int i = 1; i < TAPS; i++) dl[i] <= dl[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      coef_q <= '0;
      vs     <= '0;
    end else begin
      coef_q <= coef_in;
      vs     <= {vs[LAT-2:0], valid_in};
    end
  end

  for (genvar k = 0; k < NC; k++) begin : g_tap
    logic signed [PW-1:0] pre;
    logic signed [PW-1:0] pv [k+1];
    logic signed [CW-1:0] cv [k+1];
    logic signed [MW-1:0] prod_q;
    logic signed [OW-1:0] acc_r;

    if (k < NPAIR) begin : g_pair
      if (ANTI) begin : g_sub
        assign pre = PW'(dl[k]) - PW'(dl[TAPS-1-k]);
      end else begin : g_add
        assign pre = PW'(dl[k]) + PW'(dl[TAPS-1-k]);
      end
    end else begin : g_mid
      assign pre = PW'(dl[k]);
    end

    always_ff @(posedge clk) begin
      if (srst) begin
        for (int j = 0; j <= k; j++) begin
          pv[j] <= '0;
          cv[j] <= '0;
        end
        prod_q <= '0;
      end else begin
        pv[0] <= pre;
        cv[0] <= $signed(coef_q[k*CW +: CW]);
        for (int j = 1; j <= k; j++) begin
          pv[j] <= pv[j-1];
          cv[j] <= cv[j-1];
        end
        prod_q <= pv[k] * cv[k];
      end
    end

    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (srst) acc_r <= '0;
        else      acc_r <= OW'(prod_q);
      end
    end else begin : g_link
      always_ff @(posedge clk) begin
        if (srst) acc_r <= '0;
        else      acc_r <= g_tap[k-1].acc_r + OW'(prod_q);
      end
    end
  end

  assign valid_out = vs[LAT-1];
  assign data_out  = g_tap[NC-1].acc_r;
endmodule

// File: rtl/symfir_systolic_chk.sv
module symfir_systolic_chk #(
  parameter int DW  = 12,
  parameter int OW  = 27,
  parameter int LAT = 7
) (
  input logic                 clk,
  input logic                 srst,
  input logic                 valid_in,
  input logic signed [DW-1:0] data_in,
  input logic                 valid_out,
  input logic signed [OW-1:0] data_out
);
  logic [31:0] idle_cnt, in_tot, out_tot;
  logic        nz;

  always_ff @(posedge clk) begin
    if (srst) begin
      idle_cnt <= '0;
      in_tot   <= '0;
      out_tot  <= '0;
      nz       <= 1'b0;
    end else begin
      if (valid_in)                  idle_cnt <= '0;
      else if (idle_cnt < 32'(LAT))  idle_cnt <= idle_cnt + 1'b1;
      if (valid_in)  in_tot  <= in_tot + 1'b1;
      if (valid_out) out_tot <= out_tot + 1'b1;
      if (valid_in && data_in != '0) nz <= 1'b1;
    end
  end

  // R8
  rst_clears_out_chk: assert property (@(posedge clk)
    srst |=> (!valid_out && data_out == '0));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (srst)
    (idle_cnt >= 32'(LAT)) |-> !valid_out);

  // R6
  no_extra_out_chk: assert property (@(posedge clk) disable iff (srst)
    valid_out |-> (out_tot < in_tot));

  // R5
  zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (srst)
    (valid_out && !nz) |-> (data_out == '0));
endmodule

bind symfir_systolic symfir_systolic_chk #(.DW(DW), .OW(OW), .LAT(LAT)) u_chk (
  .clk(clk), .srst(srst), .valid_in(valid_in), .data_in(data_in),
  .valid_out(valid_out), .data_out(data_out)
);

// File: tb/symfir_systolic_tb.sv
`timescale 1ns/1ps
module symfir_systolic_tb;
  localparam int DW  = 12;
  localparam int CW  = 12;
  localparam int LS  = 7;
  localparam int LA  = 8;
  localparam int NU  = 4;
  localparam int LAT = NU + 3;
  localparam int OW  = 27;

  typedef struct {
    longint val;
    longint due;
    string  tag;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 srst = 1'b1;
  logic                 vin  = 1'b0;
  logic signed [DW-1:0] din  = '0;
  logic [NU*CW-1:0]     coef_s = '0, coef_a = '0;
  logic                 vout_s, vout_a;
  logic signed [OW-1:0] dout_s, dout_a;

  symfir_systolic #(.TAPS(LS), .DW(DW), .CW(CW), .ANTI(1'b0)) u_dut (
    .clk(clk), .srst(srst), .valid_in(vin), .data_in(din), .coef_in(coef_s),
    .valid_out(vout_s), .data_out(dout_s));

  symfir_systolic #(.TAPS(LA), .DW(DW), .CW(CW), .ANTI(1'b1)) u_anti (
    .clk(clk), .srst(srst), .valid_in(vin), .data_in(din), .coef_in(coef_a),
    .valid_out(vout_a), .data_out(dout_a));

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int     nchk = 0, nfail = 0;
  longint hist [LA];
  int     cs [NU], ca [NU];
  exp_t   q [2][$];
  bit     mon_en = 1'b0;

  task automatic step(input bit v, input int d, input string tag);
    longint es, ea;
    @(negedge clk);
    vin = v;
    din = d[DW-1:0];
    for (int k = 0; k < NU; k++) begin
      coef_s[k*CW +: CW] = cs[k][CW-1:0];
      coef_a[k*CW +: CW] = ca[k][CW-1:0];
    end
    if (v) begin
      for (int i = LA-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = d;
      es = 0;
      ea = 0;
      for (int i = 0; i < LS; i++)
        es += longint'(cs[(i < LS-1-i) ? i : LS-1-i]) * hist[i];
      for (int i = 0; i < LA; i++)
        ea += ((i < NU) ? longint'(ca[i]) : -longint'(ca[LA-1-i])) * hist[i];
      q[0].push_back('{es, cyc + LAT, {tag, " sym"}});
      q[1].push_back('{ea, cyc + LAT, {tag, " anti"}});
    end
  endtask

  function automatic int rnd();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  task automatic new_coefs();
    for (int k = 0; k < NU; k++) begin
      cs[k] = rnd();
      ca[k] = rnd();
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      for (int u = 0; u < 2; u++) begin
        logic   vo;
        longint dv;
        exp_t   e;
        vo = (u == 0) ? vout_s : vout_a;
        dv = (u == 0) ? longint'(dout_s) : longint'(dout_a);
        if (vo) begin
          nchk++;
          if (q[u].size() == 0) begin
            nfail++;
            $display("FAIL R6: unit %0d valid_out with nothing pending, got %0d expected none", u, dv);
          end else begin
            e = q[u].pop_front();
            if (dv != e.val) begin
              nfail++;
              $display("FAIL %s: got %0d expected %0d (cycle %0d)", e.tag, dv, e.val, cyc);
            end else if (cyc != e.due) begin
              nfail++;
              $display("FAIL R6: unit %0d result at cycle %0d expected cycle %0d", u, cyc, e.due);
            end
          end
        end else if (q[u].size() > 0 && q[u][0].due <= cyc) begin
          nchk++;
          nfail++;
          e = q[u].pop_front();
          $display("FAIL R6: unit %0d no valid_out at cycle %0d expected cycle %0d (%s)", u, cyc, e.due, e.tag);
        end
      end
    end
  end

  task automatic check_quiet(input string tag);
    nchk++;
    if (vout_s !== 1'b0 || vout_a !== 1'b0 || dout_s !== '0 || dout_a !== '0) begin
      nfail++;
      $display("FAIL %s: got valid %b/%b data %0d/%0d expected 0/0 0/0",
               tag, vout_s, vout_a, dout_s, dout_a);
    end
  endtask

  initial begin
    #(8 * 20000);
    nfail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < LA; i++) hist[i] = 0;
    for (int k = 0; k < NU; k++) begin
      cs[k] = 0;
      ca[k] = 0;
    end
    repeat (3) @(negedge clk);
    check_quiet("R8 reset state");
    srst = 1'b0;
    mon_en = 1'b1;

    // R1 R2 R3 impulse reads back expanded responses
    cs = '{1, 2, 3, 4};
    ca = '{5, 6, 7, 8};
    step(1'b1, 1, "R1 R2 R3 impulse");
    repeat (9) step(1'b1, 0, "R1 R2 R3 impulse");

    // R2 R3 random data, fixed coefficients
    new_coefs();
    repeat (40) step(1'b1, rnd(), "R2 R3 random");

    // R5 gaps with garbage data between strobes
    new_coefs();
    repeat (60) step(($urandom % 3) == 0, rnd(), "R5 gapped");

    // R7 coefficients change every cycle
    repeat (50) begin
      new_coefs();
      step(($urandom % 4) != 0, rnd(), "R7 coef change");
    end

    // R4 extreme codes
    for (int k = 0; k < NU; k++) begin
      cs[k] = -2048;
      ca[k] = -2048;
    end
    repeat (10) step(1'b1, -2048, "R4 extreme neg");
    repeat (10) step(1'b1, 2047, "R4 extreme pos");
    for (int n = 0; n < 12; n++) step(1'b1, (n % 2 == 0) ? -2048 : 2047, "R4 extreme alt");

    // R8 reset with samples in flight
    new_coefs();
    repeat (4) step(1'b1, rnd(), "R8 before reset");
    @(negedge clk);
    srst = 1'b1;
    vin  = 1'b0;
    for (int u = 0; u < 2; u++)
      while (q[u].size() > 0 && q[u][q[u].size()-1].due > cyc) void'(q[u].pop_back());
    for (int i = 0; i < LA; i++) hist[i] = 0;
    @(negedge clk);
    check_quiet("R8 cycle after reset");
    srst = 1'b0;
    repeat (3) step(1'b1, rnd(), "R8 after reset");
    repeat (6) step(1'b0, rnd(), "R8 after reset");

    repeat (LAT + 4) step(1'b0, 0, "drain");
    nchk++;
    if (q[0].size() != 0 || q[1].size() != 0) begin
      nfail++;
      $display("FAIL R6: pending results got %0d/%0d expected 0/0", q[0].size(), q[1].size());
    end
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule